// File: doc/BRIEF.md
# Bit-Sliced Integer ALU with Set-Less-Than

This block is a 32-bit integer arithmetic and logic unit made of identical one-bit slices chained through their carries. A 3-bit control code selects bitwise AND, bitwise OR, addition, subtraction or a signed set-less-than comparison. Subtraction reuses the adder: the control's top bit inverts the second operand in every slice and injects a carry of one into the lowest slice, so the chain forms a + ~b + 1.

For the comparison, the sign of the difference is corrected by the overflow bit and fed back into the "less" input of slice 0. Every other slice sees a constant zero there. The result, a zero flag, the carry from the top slice and a signed overflow flag are captured in an output register, with a synchronous active-high reset. A caller therefore sees the answer one clock after presenting operands and a control code.

Top module: `bitslice_alu`

## Requirements
- R1: Control code 000 makes the result the bitwise AND of the operands.
- R2: Control code 001 makes the result the bitwise OR of the operands.
- R3: Control code 010 makes the result (a + b) mod 2^32, and the carry output is the carry out of bit 31.
- R4: Control code 110 makes the result (a - b) mod 2^32, and the carry output is the carry out of bit 31 of a + ~b + 1, which is 1 exactly when a >= b as unsigned numbers.
- R5: Control code 111 makes result bit 0 equal to 1 exactly when a < b as signed two's complement numbers, including when a - b overflows; result bits 31..1 are 0.
- R6: The zero output is 1 exactly when all 32 result bits are 0.
- R7: For codes 010 and 110, the overflow output is 1 exactly when the effective addition of two same-signed values gives a result of the other sign; operands of opposite effective sign never overflow. For all other codes both the overflow and the carry outputs are 0.
- R8: Codes 011, 100 and 101 give an all-zero result with zero = 1.
- R9: While reset is high at a rising edge, the outputs become result 0, zero 1, carry 0, overflow 0.
- R10: Outputs change only at a rising clock edge and reflect the operands and code present at that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_a | input | 32 | First operand |
| op_b | input | 32 | Second operand |
| ctl | input | 3 | Operation code |
| res | output | 32 | Registered result |
| zero | output | 1 | Result-is-zero flag |
| cout | output | 1 | Carry out of the top slice (add and subtract) |
| ovf | output | 1 | Signed overflow (add and subtract) |

## Verification
The hardest situation to reach is a comparison where the subtraction itself overflows. In that case the raw sign bit of the difference gives the wrong answer, and only the overflow correction fed back into slice 0 gives the right one. The stimulus table pairs the extreme values 8000_0000 and 7FFF_FFFF with small and negative operands in both orders. It also includes the same pairs under add and subtract, so the carry into and out of the top slice is driven through every combination.

// File: rtl/alu_pkg.sv
package alu_pkg;
  localparam logic [2:0] CTL_AND = 3'b000;
  localparam logic [2:0] CTL_OR  = 3'b001;
  localparam logic [2:0] CTL_ADD = 3'b010;
  localparam logic [2:0] CTL_SUB = 3'b110;
  localparam logic [2:0] CTL_SLT = 3'b111;

  typedef enum logic [1:0] {
    PICK_AND  = 2'd0,
    PICK_OR   = 2'd1,
    PICK_SUM  = 2'd2,
    PICK_LESS = 2'd3
  } slice_pick_t;
endpackage

// File: rtl/alu_op_decode.sv
module alu_op_decode
  import alu_pkg::*;
(
  input  logic [2:0]  ctl,
  output logic        invert_b,
  output slice_pick_t pick,
  output logic        is_arith,
  output logic        is_legal
);
  always_comb begin
    invert_b = 1'b0;
    pick     = PICK_AND;
    is_arith = 1'b0;
    is_legal = 1'b1;
    case (ctl)
      CTL_AND: pick = PICK_AND;
      CTL_OR:  pick = PICK_OR;
      CTL_ADD: begin
        pick     = PICK_SUM;
        is_arith = 1'b1;
      end
      CTL_SUB: begin
        pick     = PICK_SUM;
        invert_b = 1'b1;
        is_arith = 1'b1;
      end
      CTL_SLT: begin
        pick     = PICK_LESS;
        invert_b = 1'b1;
      end
      default: is_legal = 1'b0;
    endcase
  end
endmodule

// File: rtl/alu_bit_slice.sv
module alu_bit_slice
  import alu_pkg::*;
(
  input  logic        a,
  input  logic        b,
  input  logic        invert_b,
  input  logic        carry_in,
  input  logic        less,
  input  slice_pick_t pick,
  output logic        result,
  output logic        sum,
  output logic        carry_out
);
  logic b_eff;

  always_comb begin
    b_eff     = b ^ invert_b;
    sum       = a ^ b_eff ^ carry_in;
    carry_out = (a & b_eff) | (carry_in & (a ^ b_eff));
    case (pick)
      PICK_AND: result = a & b_eff;
      PICK_OR:  result = a | b_eff;
      PICK_SUM: result = sum;
      default:  result = less;
    endcase
  end
endmodule

// File: rtl/bitslice_alu.sv
module bitslice_alu #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] op_a,
  input  logic [W-1:0] op_b,
  input  logic [2:0]   ctl,
  output logic [W-1:0] res,
  output logic         zero,
  output logic         cout,
  output logic         ovf
);
  import alu_pkg::*;

  localparam int TOP = W - 1;

  logic        invert_b;
  slice_pick_t pick;
  logic        is_arith;
  logic        is_legal;

  logic [W:0]   carry;
  logic [W-1:0] sum_bits;
  logic [W-1:0] slice_res;
  logic [W-1:0] less_bits;
  logic         ovf_raw;
  logic         less_bit;
  logic [W-1:0] res_next;

  alu_op_decode u_dec (
    .ctl      (ctl),
    .invert_b (invert_b),
    .pick     (pick),
    .is_arith (is_arith),
    .is_legal (is_legal)
  );

  assign carry[0] = invert_b;

  for (genvar i = 0; i < W; i++) begin : g_slice
    if (i == 0) begin : g_lsb
      assign less_bits[i] = less_bit;
    end else begin : g_rest
      assign less_bits[i] = 1'b0;
    end
    alu_bit_slice u_bit (
      .a         (op_a[i]),
      .b         (op_b[i]),
      .invert_b  (invert_b),
      .carry_in  (carry[i]),
      .less      (less_bits[i]),
      .pick      (pick),
      .result    (slice_res[i]),
      .sum       (sum_bits[i]),
      .carry_out (carry[i+1])
    );
  end

  assign ovf_raw  = carry[W] ^ carry[TOP];
  assign less_bit = sum_bits[TOP] ^ ovf_raw;
  assign res_next = is_legal ? slice_res : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      res  <= '0;
      zero <= 1'b1;
      cout <= 1'b0;
      ovf  <= 1'b0;
    end else begin
      res  <= res_next;
      zero <= (res_next == '0);
      cout <= is_arith & carry[W];
      ovf  <= is_arith & ovf_raw;
    end
  end
endmodule

// File: rtl/alu_checks.sv
module alu_checks #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst,
  input logic [W-1:0] op_a,
  input logic [W-1:0] op_b,
  input logic [2:0]   ctl,
  input logic [W-1:0] res,
  input logic         zero,
  input logic         cout,
  input logic         ovf
);
  logic armed;
  always_ff @(posedge clk) begin
    if (rst) armed <= 1'b1;
  end

  AST_AND_RESULT: assert property (@(posedge clk) disable iff (rst)
    (armed && $past(!rst) && $past(ctl) == 3'b000) |-> (res == ($past(op_a) & $past(op_b)))); // R1
  AST_OR_RESULT: assert property (@(posedge clk) disable iff (rst)
    (armed && $past(!rst) && $past(ctl) == 3'b001) |-> (res == ($past(op_a) | $past(op_b)))); // R2
  AST_ADD_RESULT: assert property (@(posedge clk) disable iff (rst)
    (armed && $past(!rst) && $past(ctl) == 3'b010) |-> (res == $past(op_a) + $past(op_b))); // R3
  AST_SUB_RESULT: assert property (@(posedge clk) disable iff (rst)
    (armed && $past(!rst) && $past(ctl) == 3'b110) |-> (res == $past(op_a) - $past(op_b))); // R4
  AST_SLT_UPPER: assert property (@(posedge clk) disable iff (rst)
    (armed && $past(!rst) && $past(ctl) == 3'b111) |-> (res[W-1:1] == '0)); // R5
  AST_ZERO_FLAG: assert property (@(posedge clk) disable iff (rst)
    armed |-> (zero == (res == '0))); // R6
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    (armed && $past(!rst) && $past(ctl) == 3'b010 && ($past(op_a[W-1]) != $past(op_b[W-1]))) |-> !ovf); // R7
  AST_BAD_CODE: assert property (@(posedge clk) disable iff (rst)
    (armed && $past(!rst) && ($past(ctl) == 3'b011 || $past(ctl) == 3'b100 || $past(ctl) == 3'b101))
      |-> (res == '0 && zero && !cout && !ovf)); // R8
  AST_RESET_STATE: assert property (@(posedge clk)
    (armed && $past(rst)) |-> (res == '0 && zero && !cout && !ovf)); // R9
endmodule

bind bitslice_alu alu_checks #(.W(W)) u_alu_checks (
  .clk  (clk),
  .rst  (rst),
  .op_a (op_a),
  .op_b (op_b),
  .ctl  (ctl),
  .res  (res),
  .zero (zero),
  .cout (cout),
  .ovf  (ovf)
);

// File: tb/bitslice_alu_bench.sv
module bitslice_alu_bench;
  localparam int W  = 32;
  localparam int NV = 22;

  logic         clk = 1'b0;
  logic         rst;
  logic [W-1:0] op_a, op_b;
  logic [2:0]   ctl;
  logic [W-1:0] res;
  logic         zero, cout, ovf;

  int errors = 0;
  int checks = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  bitslice_alu #(.W(W)) u_bitslice_alu (
    .clk(clk), .rst(rst), .op_a(op_a), .op_b(op_b), .ctl(ctl),
    .res(res), .zero(zero), .cout(cout), .ovf(ovf)
  );

  // ctl, a, b, expected result, expected {zero,cout,ovf}, requirement number
  localparam logic [2:0] T_CTL [NV] = '{
    3'b000, 3'b001, 3'b000, 3'b010, 3'b010, 3'b010, 3'b010, 3'b010,
    3'b110, 3'b110, 3'b110, 3'b110, 3'b110,
    3'b111, 3'b111, 3'b111, 3'b111, 3'b111,
    3'b011, 3'b100, 3'b101, 3'b111};
  localparam logic [31:0] T_A [NV] = '{
    32'hF0F0_1234, 32'hF0F0_0000, 32'hAAAA_AAAA, 32'h0000_0007, 32'hFFFF_FFFF,
    32'h7FFF_FFFF, 32'h8000_0000, 32'h8000_0000,
    32'h0000_000A, 32'h0000_0003, 32'h0000_0005, 32'h8000_0000, 32'h7FFF_FFFF,
    32'h0000_0003, 32'h0000_0005, 32'hFFFF_FFFF, 32'h8000_0000, 32'h7FFF_FFFF,
    32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h0000_0004};
  localparam logic [31:0] T_B [NV] = '{
    32'h0FF0_FF00, 32'h0F00_00AA, 32'h5555_5555, 32'h0000_0005, 32'h0000_0001,
    32'h0000_0001, 32'h8000_0000, 32'h7FFF_FFFF,
    32'h0000_0003, 32'h0000_000A, 32'h0000_0005, 32'h0000_0001, 32'hFFFF_FFFF,
    32'h0000_0005, 32'h0000_0003, 32'h0000_0001, 32'h0000_0001, 32'hFFFF_FFFF,
    32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h0000_0004};
  localparam logic [31:0] T_RES [NV] = '{
    32'h00F0_1200, 32'hFFF0_00AA, 32'h0000_0000, 32'h0000_000C, 32'h0000_0000,
    32'h8000_0000, 32'h0000_0000, 32'hFFFF_FFFF,
    32'h0000_0007, 32'hFFFF_FFF9, 32'h0000_0000, 32'h7FFF_FFFF, 32'h8000_0000,
    32'h0000_0001, 32'h0000_0000, 32'h0000_0001, 32'h0000_0001, 32'h0000_0000,
    32'h0000_0000, 32'h0000_0000, 32'h0000_0000, 32'h0000_0000};
  localparam logic [2:0] T_FLG [NV] = '{
    3'b000, 3'b000, 3'b100, 3'b000, 3'b110, 3'b001, 3'b111, 3'b000,
    3'b010, 3'b000, 3'b110, 3'b011, 3'b001,
    3'b000, 3'b100, 3'b000, 3'b000, 3'b100,
    3'b100, 3'b100, 3'b100, 3'b100};
  // R1 and, R2 or, R6 zero, R3 add, R7 overflow, R4 sub, R5 slt, R8 undefined
  localparam int T_REQ [NV] = '{
    1, 2, 6, 3, 3, 7, 7, 7,
    4, 4, 4, 7, 7,
    5, 5, 5, 5, 5,
    8, 8, 8, 5};

  task automatic check_val(input int req, input string what,
                           input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL R%0d %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic check_all(input int req, input logic [31:0] er, input logic [2:0] ef);
    check_val(req, "result", res, er);
    check_val(req, "zero/cout/ovf", {29'd0, zero, cout, ovf}, {29'd0, ef});
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL R10 watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst  = 1'b1;
    ctl  = 3'b010;
    op_a = 32'hFFFF_FFFF;
    op_b = 32'h0000_0001;
    repeat (3) @(negedge clk);
    // R9: reset state while an add with carry is presented
    check_all(9, 32'h0, 3'b100);
    rst = 1'b0;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      ctl  = T_CTL[i];
      op_a = T_A[i];
      op_b = T_B[i];
      @(negedge clk);
      check_all(T_REQ[i], T_RES[i], T_FLG[i]);
    end

    // R10: new inputs do not reach the outputs before the next rising edge
    ctl  = 3'b010;
    op_a = 32'h0000_0010;
    op_b = 32'h0000_0020;
    @(negedge clk);
    check_val(10, "result after edge", res, 32'h0000_0030);
    op_a = 32'h0000_0100;
    #2;
    check_val(10, "result held between edges", res, 32'h0000_0030);
    @(negedge clk);
    check_val(10, "result after next edge", res, 32'h0000_0120);

    // R9: reset asserted mid-run clears a non-zero result and flags
    ctl  = 3'b010;
    op_a = 32'h7FFF_FFFF;
    op_b = 32'h0000_0001;
    @(negedge clk);
    check_all(7, 32'h8000_0000, 3'b001);
    rst = 1'b1;
    @(negedge clk);
    check_all(9, 32'h0, 3'b100);
    rst = 1'b0;

    // R1/R2 with all-ones and all-zeros operands
    ctl  = 3'b001;
    op_a = 32'h0;
    op_b = 32'h0;
    @(negedge clk);
    check_all(2, 32'h0, 3'b100);
    ctl  = 3'b000;
    op_a = 32'hFFFF_FFFF;
    op_b = 32'hFFFF_FFFF;
    @(negedge clk);
    check_all(1, 32'hFFFF_FFFF, 3'b000);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule